// File: doc/BRIEF.md
# Burst Address and Command Sequencer

This block sits at the front of a synchronous burst memory port. On every rising clock edge that is not held, it samples a 19-bit address, three chip selects, a read/write select, two active-low byte enables and an advance/load strobe. It sorts the cycle into one of five kinds:

- hold
- deselect
- read load
- write load
- continue

From that it produces a registered command record (valid, write flag, address, byte mask) for the storage datapath behind it.

A load cycle starts a burst at the external address. Continue cycles then walk the two lowest address bits with a private burst counter. The order is linear or interleaved, chosen by a mode pin. Each continue cycle repeats the operation type latched when the burst began.

A three-state machine tracks the burst kind. The states are `ST_DESEL`, `ST_RD` and `ST_WR`. The transitions are:

- A deselect load goes to `ST_DESEL` from any state.
- A read load goes to `ST_RD` from any state.
- A write load goes to `ST_WR` from any state.
- A continue cycle keeps the current state.
- A hold keeps the current state.

Synchronous reset enters `ST_DESEL` with the counter cleared.

Top module: `bseq_top`

## Requirements
- R1: A load cycle (adv_i=0) with all selects active (sel_a_n_i=0, sel_b_i=1, sel_c_n_i=0) and rd_wr_i=1 gives, one clock later, cmd_valid_o=1, cmd_write_o=0, cmd_addr_o equal to the sampled addr_i, and cmd_mask_o=00.
- R2: The same load with rd_wr_i=0 and at least one byte enable low gives cmd_valid_o=1 and cmd_write_o=1, with cmd_addr_o equal to addr_i. In cmd_mask_o, bit i is set when bwe_n_i[i] is low; bit 0 is the low byte.
- R3: With ilv_i=1, the k-th continue cycle of a burst outputs low address bits equal to (start XOR (k mod 4)). The upper 17 bits stay those of the load, so the address returns to the start after every fourth continue.
- R4: With ilv_i=0, the k-th continue cycle outputs low bits equal to (start + k) mod 4, with the upper bits kept.
- R5: A load cycle with any select inactive (sel_a_n_i=1, sel_b_i=0 or sel_c_n_i=1) gives cmd_valid_o=0.
- R6: A continue cycle while deselected gives cmd_valid_o=0, and the sequencer stays deselected.
- R7: A write load or continue-write cycle with both byte enables high is aborted (cmd_valid_o=0). Byte enables are sampled again on every continue-write cycle, which issues a write when any enable is low.
- R8: A cycle with hold_i=1 gives cmd_valid_o=0 and leaves cmd_write_o, cmd_addr_o and cmd_mask_o unchanged. The burst counter and state also stay unchanged, so the next continue resumes the sequence.
- R9: While rst is high, and one clock after it, all outputs are zero and the sequencer is deselected.
- R10: In a read burst, continue cycles issue reads (cmd_valid_o=1, cmd_write_o=0, cmd_mask_o=00) whatever addr_i, the selects and rd_wr_i hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hold_i | input | 1 | Freezes the cycle when high |
| adv_i | input | 1 | 1 = continue burst, 0 = load new command |
| addr_i | input | 19 | External address |
| sel_a_n_i | input | 1 | Chip select, active low |
| sel_b_i | input | 1 | Chip select, active high |
| sel_c_n_i | input | 1 | Chip select, active low |
| rd_wr_i | input | 1 | 1 = read burst, 0 = write burst |
| bwe_n_i | input | 2 | Byte write enables, active low |
| ilv_i | input | 1 | 1 = interleaved order, 0 = linear |
| cmd_valid_o | output | 1 | Command issued this cycle |
| cmd_write_o | output | 1 | Command is a write |
| cmd_addr_o | output | 19 | Command address |
| cmd_mask_o | output | 2 | Bytes to write, active high |

## Verification
Directed bursts start from each of the four low-address values and run five continue cycles. This is done in interleaved order and in linear order, so the two step functions and the wrap after four cycles are told apart. Write bursts mix full, partial and empty byte enables, which separates genuine writes from aborts on both load and continue cycles. Holds placed mid-burst show that the counter resumes rather than skips. Deselect loads that drive each select inactive in turn, and continues that follow them, confirm that the selects are decoded one by one. A seeded random stream then mixes all five cycle kinds under both orders, so that state carried across kinds is exercised as well.

// File: rtl/bseq_pkg.sv
`timescale 1ns/1ps
package bseq_pkg;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_RD    = 2'd1,
        ST_WR    = 2'd2
    } burst_state_e;

    typedef enum logic [2:0] {
        CY_HOLD    = 3'd0,
        CY_DESEL   = 3'd1,
        CY_LOAD_RD = 3'd2,
        CY_LOAD_WR = 3'd3,
        CY_CONT    = 3'd4
    } cycle_kind_e;

endpackage

// File: rtl/bseq_classify.sv
`timescale 1ns/1ps
module bseq_classify
    import bseq_pkg::*;
(
    input  logic        hold_i,
    input  logic        adv_i,
    input  logic        sel_a_n_i,
    input  logic        sel_b_i,
    input  logic        sel_c_n_i,
    input  logic        rd_wr_i,
    output cycle_kind_e kind_o
);

    logic selected;

    assign selected = !sel_a_n_i && sel_b_i && !sel_c_n_i;

    // Hold wins over everything; advance wins over the load-side inputs.
    always_comb begin
        if (hold_i) begin
            kind_o = CY_HOLD;
        end else if (adv_i) begin
            kind_o = CY_CONT;
        end else if (!selected) begin
            kind_o = CY_DESEL;
        end else if (rd_wr_i) begin
            kind_o = CY_LOAD_RD;
        end else begin
            kind_o = CY_LOAD_WR;
        end
    end

endmodule

// File: rtl/bseq_burst_ctr.sv
`timescale 1ns/1ps
module bseq_burst_ctr
    import bseq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  cycle_kind_e      kind_i,
    input  logic [CNT_W-1:0] start_i,
    input  logic             ilv_i,
    output logic [CNT_W-1:0] low_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] base_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] lin_low;
    logic [CNT_W-1:0] ilv_low;

    assign step    = cnt_q + ONE;
    assign lin_low = base_q + step;

    // Interleaved order: each low bit toggles against the step count.
    for (genvar g = 0; g < CNT_W; g++) begin : g_ilv
        assign ilv_low[g] = base_q[g] ^ step[g];
    end

    always_comb begin
        if (kind_i == CY_CONT) begin
            low_o = ilv_i ? ilv_low : lin_low;
        end else begin
            low_o = start_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            unique case (kind_i)
                CY_LOAD_RD, CY_LOAD_WR: begin
                    base_q <= start_i;
                    cnt_q  <= '0;
                end
                CY_CONT: begin
                    cnt_q <= step;
                end
                default: begin
                    base_q <= base_q;
                    cnt_q  <= cnt_q;
                end
            endcase
        end
    end

endmodule

// File: rtl/bseq_cmd_reg.sv
`timescale 1ns/1ps
module bseq_cmd_reg #(
    parameter int ADDR_W = 19,
    parameter int NBYTE  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              freeze_i,
    input  logic              valid_d,
    input  logic              write_d,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic [NBYTE-1:0]  mask_d,
    output logic              valid_q,
    output logic              write_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [NBYTE-1:0]  mask_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            write_q <= 1'b0;
            addr_q  <= '0;
            mask_q  <= '0;
        end else if (freeze_i) begin
            // Fields keep their value, but nothing is issued twice.
            valid_q <= 1'b0;
        end else begin
            valid_q <= valid_d;
            write_q <= write_d;
            addr_q  <= addr_d;
            mask_q  <= mask_d;
        end
    end

endmodule

// File: rtl/bseq_top.sv
`timescale 1ns/1ps
module bseq_top
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int NBYTE  = 2,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_i,
    input  logic              adv_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              sel_a_n_i,
    input  logic              sel_b_i,
    input  logic              sel_c_n_i,
    input  logic              rd_wr_i,
    input  logic [NBYTE-1:0]  bwe_n_i,
    input  logic              ilv_i,
    output logic              cmd_valid_o,
    output logic              cmd_write_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [NBYTE-1:0]  cmd_mask_o
);

    localparam int HI_W = ADDR_W - CNT_W;

    cycle_kind_e      kind;
    burst_state_e     state_q;
    burst_state_e     state_d;
    logic [HI_W-1:0]  hi_q;
    logic [CNT_W-1:0] low;
    logic [NBYTE-1:0] byte_en;
    logic             valid_d;
    logic             write_d;
    logic [ADDR_W-1:0] addr_d;
    logic [NBYTE-1:0] mask_d;

    assign byte_en = ~bwe_n_i;

    bseq_classify u_classify (
        .hold_i    (hold_i),
        .adv_i     (adv_i),
        .sel_a_n_i (sel_a_n_i),
        .sel_b_i   (sel_b_i),
        .sel_c_n_i (sel_c_n_i),
        .rd_wr_i   (rd_wr_i),
        .kind_o    (kind)
    );

    bseq_burst_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .kind_i  (kind),
        .start_i (addr_i[CNT_W-1:0]),
        .ilv_i   (ilv_i),
        .low_o   (low)
    );

    // Next-state selection.
    always_comb begin
        unique case (kind)
            CY_DESEL:   state_d = ST_DESEL;
            CY_LOAD_RD: state_d = ST_RD;
            CY_LOAD_WR: state_d = ST_WR;
            default:    state_d = state_q;
        endcase
    end

    // State register, together with the latched upper address of the burst.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_DESEL;
            hi_q    <= '0;
        end else begin
            state_q <= state_d;
            if (kind == CY_LOAD_RD || kind == CY_LOAD_WR) begin
                hi_q <= addr_i[ADDR_W-1:CNT_W];
            end
        end
    end

    // Command that the current cycle issues.
    always_comb begin
        valid_d = 1'b0;
        write_d = 1'b0;
        mask_d  = '0;
        addr_d  = {(kind == CY_CONT) ? hi_q : addr_i[ADDR_W-1:CNT_W], low};
        unique case (kind)
            CY_LOAD_RD: begin
                valid_d = 1'b1;
            end
            CY_LOAD_WR: begin
                valid_d = |byte_en;
                write_d = 1'b1;
                mask_d  = byte_en;
            end
            CY_CONT: begin
                unique case (state_q)
                    ST_RD: begin
                        valid_d = 1'b1;
                    end
                    ST_WR: begin
                        valid_d = |byte_en;
                        write_d = 1'b1;
                        mask_d  = byte_en;
                    end
                    default: begin
                        valid_d = 1'b0;
                    end
                endcase
            end
            default: begin
                valid_d = 1'b0;
            end
        endcase
    end

    bseq_cmd_reg #(.ADDR_W(ADDR_W), .NBYTE(NBYTE)) u_cmd (
        .clk      (clk),
        .rst      (rst),
        .freeze_i (hold_i),
        .valid_d  (valid_d),
        .write_d  (write_d),
        .addr_d   (addr_d),
        .mask_d   (mask_d),
        .valid_q  (cmd_valid_o),
        .write_q  (cmd_write_o),
        .addr_q   (cmd_addr_o),
        .mask_q   (cmd_mask_o)
    );

endmodule

// File: rtl/bseq_chk.sv
`timescale 1ns/1ps
module bseq_chk
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int NBYTE  = 2,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              hold_i,
    input logic              adv_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              sel_a_n_i,
    input logic              sel_b_i,
    input logic              sel_c_n_i,
    input logic              rd_wr_i,
    input logic [NBYTE-1:0]  bwe_n_i,
    input burst_state_e      state_q,
    input logic              cmd_valid_o,
    input logic              cmd_write_o,
    input logic [ADDR_W-1:0] cmd_addr_o,
    input logic [NBYTE-1:0]  cmd_mask_o
);

    logic sel_ok;
    assign sel_ok = !sel_a_n_i && sel_b_i && !sel_c_n_i;

    // R9
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!cmd_valid_o && !cmd_write_o && cmd_addr_o == '0 && cmd_mask_o == '0));

    // R8
    hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> (!cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_mask_o) && $stable(cmd_write_o)));

    // R1
    rd_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold_i && !adv_i && sel_ok && rd_wr_i)
        |=> (cmd_valid_o && !cmd_write_o && cmd_addr_o == $past(addr_i) && cmd_mask_o == '0));

    // R5
    desel_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold_i && !adv_i && !sel_ok) |=> !cmd_valid_o);

    // R6
    idle_cont_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold_i && adv_i && state_q == ST_DESEL) |=> (!cmd_valid_o && state_q == ST_DESEL));

    // R7
    write_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold_i && !adv_i && sel_ok && !rd_wr_i && (&bwe_n_i)) |=> !cmd_valid_o);

    // R7
    write_has_bytes_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_o && cmd_write_o) |-> (cmd_mask_o != '0));

    // R3
    burst_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold_i && adv_i && state_q != ST_DESEL)
        |=> (cmd_addr_o[ADDR_W-1:CNT_W] == $past(cmd_addr_o[ADDR_W-1:CNT_W])));

    // R10
    cont_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold_i && adv_i && state_q == ST_RD)
        |=> (cmd_valid_o && !cmd_write_o && cmd_mask_o == '0));

endmodule

bind bseq_top bseq_chk #(.ADDR_W(ADDR_W), .NBYTE(NBYTE), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .hold_i      (hold_i),
    .adv_i       (adv_i),
    .addr_i      (addr_i),
    .sel_a_n_i   (sel_a_n_i),
    .sel_b_i     (sel_b_i),
    .sel_c_n_i   (sel_c_n_i),
    .rd_wr_i     (rd_wr_i),
    .bwe_n_i     (bwe_n_i),
    .state_q     (state_q),
    .cmd_valid_o (cmd_valid_o),
    .cmd_write_o (cmd_write_o),
    .cmd_addr_o  (cmd_addr_o),
    .cmd_mask_o  (cmd_mask_o)
);

// File: tb/bseq_top_bench.sv
`timescale 1ns/1ps
module bseq_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hold_i = 1'b0;
    logic        adv_i = 1'b1;
    logic [18:0] addr_i = '0;
    logic        sel_a_n_i = 1'b0;
    logic        sel_b_i = 1'b1;
    logic        sel_c_n_i = 1'b0;
    logic        rd_wr_i = 1'b1;
    logic [1:0]  bwe_n_i = 2'b11;
    logic        ilv_i = 1'b1;
    logic        cmd_valid;
    logic        cmd_write;
    logic [18:0] cmd_addr;
    logic [1:0]  cmd_mask;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Reference model state
    int          m_state = 0;
    logic [16:0] m_hi = '0;
    logic [1:0]  m_start = '0;
    logic [1:0]  m_cnt = '0;

    always #2.5 clk = ~clk;

    bseq_top u_bseq_top (
        .clk         (clk),
        .rst         (rst),
        .hold_i      (hold_i),
        .adv_i       (adv_i),
        .addr_i      (addr_i),
        .sel_a_n_i   (sel_a_n_i),
        .sel_b_i     (sel_b_i),
        .sel_c_n_i   (sel_c_n_i),
        .rd_wr_i     (rd_wr_i),
        .bwe_n_i     (bwe_n_i),
        .ilv_i       (ilv_i),
        .cmd_valid_o (cmd_valid),
        .cmd_write_o (cmd_write),
        .cmd_addr_o  (cmd_addr),
        .cmd_mask_o  (cmd_mask)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [1:0] burst_low(input logic [1:0] st, input logic [1:0] k,
                                             input logic il);
        return il ? (st ^ k) : (st + k);
    endfunction

    // One clock cycle: drive at negedge, check at the following negedge.
    task automatic cyc(input logic h, input logic a, input logic [18:0] ad,
                       input logic sa, input logic sb, input logic sc,
                       input logic rw, input logic [1:0] bw, input logic il);
        logic        pv_w;
        logic [18:0] pv_a;
        logic [1:0]  pv_m;
        logic        ev;
        logic        ew;
        logic [18:0] ea;
        logic [1:0]  em;
        logic [1:0]  en;
        string       tv;
        string       ta;
        pv_w = cmd_write; pv_a = cmd_addr; pv_m = cmd_mask;
        hold_i = h; adv_i = a; addr_i = ad; sel_a_n_i = sa; sel_b_i = sb;
        sel_c_n_i = sc; rd_wr_i = rw; bwe_n_i = bw; ilv_i = il;
        en = ~bw; ev = 1'b0; ew = 1'b0; ea = '0; em = '0; tv = "R8"; ta = "R8";
        if (h) begin
            tv = "R8";
        end else if (!a) begin
            ea = ad; ta = "";
            if (sa || !sb || sc) begin
                tv = "R5"; m_state = 0;
            end else if (rw) begin
                tv = "R1"; ev = 1'b1; m_state = 1;
                m_hi = ad[18:2]; m_start = ad[1:0]; m_cnt = '0;
            end else begin
                tv = (en == 2'b00) ? "R7" : "R2"; ev = |en; ew = 1'b1; em = en;
                m_state = 2; m_hi = ad[18:2]; m_start = ad[1:0]; m_cnt = '0;
            end
            ta = tv;
        end else begin
            m_cnt = m_cnt + 2'd1;
            ta = il ? "R3" : "R4";
            ea = {m_hi, burst_low(m_start, m_cnt, il)};
            if (m_state == 0) begin
                tv = "R6";
            end else if (m_state == 1) begin
                tv = "R10"; ev = 1'b1;
            end else begin
                tv = "R7"; ev = |en; ew = 1'b1; em = en;
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(cmd_valid == ev, tv, "valid", 32'(cmd_valid), 32'(ev));
        if (h) begin
            chk(cmd_write == pv_w && cmd_addr == pv_a && cmd_mask == pv_m, "R8",
                "held fields", {12'd0, cmd_write, cmd_addr}, {12'd0, pv_w, pv_a});
        end else if (ev) begin
            chk(cmd_write == ew, tv, "write", 32'(cmd_write), 32'(ew));
            chk(cmd_addr == ea, ta, "addr", 32'(cmd_addr), 32'(ea));
            chk(cmd_mask == em, tv, "mask", 32'(cmd_mask), 32'(em));
        end
    endtask

    task automatic load_rd(input logic [18:0] ad, input logic il);
        cyc(1'b0, 1'b0, ad, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, il);
    endtask

    task automatic load_wr(input logic [18:0] ad, input logic [1:0] bw, input logic il);
        cyc(1'b0, 1'b0, ad, 1'b0, 1'b1, 1'b0, 1'b0, bw, il);
    endtask

    task automatic cont(input logic [1:0] bw, input logic il);
        // Load-side inputs scrambled: a continue must ignore them (R10).
        cyc(1'b0, 1'b1, 19'h5A5A5, 1'b1, 1'b0, 1'b1, 1'b0, bw, il);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R9: outputs cleared during reset
        repeat (3) @(negedge clk);
        chk(cmd_valid == 1'b0 && cmd_write == 1'b0 && cmd_addr == '0 && cmd_mask == '0,
            "R9", "reset outputs", {12'd0, cmd_valid, cmd_addr}, 32'd0);
        rst = 1'b0;
        // R9/R6: deselected after reset, continue issues nothing
        cyc(1'b0, 1'b1, 19'h00003, 1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 1'b1);

        // R3: interleaved bursts from every start, five continues (wrap)
        for (int s = 0; s < 4; s++) begin
            load_rd({17'h1ABCD, 2'(s)}, 1'b1);
            for (int k = 0; k < 5; k++) cont(2'b11, 1'b1);
        end
        // R4: linear bursts from every start
        for (int s = 0; s < 4; s++) begin
            load_rd({17'h0F0F0, 2'(s)}, 1'b0);
            for (int k = 0; k < 5; k++) cont(2'b11, 1'b0);
        end
        // R2/R7: write burst with full, partial and empty byte enables
        load_wr(19'h12341, 2'b00, 1'b0);
        cont(2'b01, 1'b0);
        cont(2'b11, 1'b0);
        cont(2'b10, 1'b0);
        cont(2'b00, 1'b0);
        // R7: aborted write load, then a continue that writes
        load_wr(19'h3FFFE, 2'b11, 1'b1);
        cont(2'b10, 1'b1);
        cont(2'b11, 1'b1);
        // R5/R6: each select inactive in turn, followed by a continue
        cyc(1'b0, 1'b0, 19'h00100, 1'b1, 1'b1, 1'b0, 1'b1, 2'b00, 1'b0);
        cont(2'b00, 1'b0);
        cyc(1'b0, 1'b0, 19'h00200, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
        cont(2'b00, 1'b0);
        cyc(1'b0, 1'b0, 19'h00300, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0);
        cont(2'b00, 1'b0);
        // R8: holds in the middle of a read burst and of a write burst
        load_rd(19'h7FFF2, 1'b1);
        cont(2'b11, 1'b1);
        cyc(1'b1, 1'b1, 19'h00000, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1);
        cyc(1'b1, 1'b0, 19'h11111, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1);
        cont(2'b11, 1'b1);
        load_wr(19'h04443, 2'b10, 1'b0);
        cyc(1'b1, 1'b1, 19'h00000, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0);
        cont(2'b01, 1'b0);

        // Seeded random mix of all cycle kinds
        for (int i = 0; i < 800; i++) begin
            logic h, a, sa, sb, sc, rw, il;
            logic [1:0] bw;
            logic [18:0] ad;
            int r;
            h  = (($urandom % 8) == 0);
            a  = ($urandom % 2) == 1;
            r  = $urandom % 6;
            sa = (r == 0); sb = (r != 1); sc = (r == 2);
            rw = ($urandom % 2) == 1;
            bw = 2'($urandom % 4);
            ad = 19'($urandom);
            il = ((i / 100) % 2) == 1;
            cyc(h, a, ad, sa, sb, sc, rw, bw, il);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule